// File: doc/BRIEF.md
# Timer-Triggered Pulse Pattern Port

This block drives a 16-bit output pattern that is made of two 8-bit ports. Each pin bit has four bits of state: a direction bit, a pattern-enable bit, a buffered next-value bit and a data bit. The data bit is what the pin carries. Software fills the next-value registers ahead of time. A compare-match pulse from an external timer channel then copies them into the data registers for every enabled bit, so the pin pattern changes on a hardware timing edge and not on a software write.

The pins are split into four 4-bit groups. Each group has its own 2-bit field in a trigger-select register, and that field picks one of four compare-match inputs. A group can therefore step on its own timer channel. While pattern output is enabled for a bit, software writes to that bit's data register are blocked, and only the trigger transfer can change it. When a bit's direction is 0 the pin is an input. Transfers still take place into its data register, and a read of the data address returns the live pin level for that bit.

Top module: `pulse_pattern_port`

## Requirements
- R1: A synchronous reset clears every register. After reset, pin_oe and pin_out are all 0, every pin is an input, and bus_rdata reads 0.
- R2: pin_oe bit i equals direction bit i. pin_out bit i always carries data bit i, whatever the enable bit is. Direction registers are at address 0 (bits 7:0) and address 1 (bits 15:8).
- R3: A bus write to the data register updates each bit whose enable bit is 0, and the new value shows on pin_out after the write edge. The data registers are at address 4 (bits 7:0) and address 5 (bits 15:8).
- R4: A bus write to the data register leaves unchanged every bit whose enable bit is 1, for either direction.
- R5: A compare-match pulse selected by a group copies the next-value bit into the data bit for every enabled bit of that group, on the edge where the pulse is high. Setting an enable bit (address 6 for bits 7:0, address 7 for bits 15:8) does not change the data bit by itself.
- R6: A compare-match pulse that a group does not select leaves that group unchanged. Bits whose enable bit is 0 are never changed by a trigger.
- R7: The trigger-select register is at address 8. Field [2g+1:2g] selects which compare-match input (0 to 3) steps group g, where group g covers pin bits 4g+3 to 4g.
- R8: A bit that is enabled but has direction 0 still receives trigger transfers, and these show on pin_out.
- R9: When a data write and a selected trigger land in the same cycle, the enabled bits take the next value and the non-enabled bits take the written value.
- R10: A read returns, one cycle after bus_addr is presented, the register at that address. The address map is: 0/1 direction, 2/3 next value, 4/5 data, 6/7 enable, 8 trigger select. For a data address, bits with direction 1 return the data bit and bits with direction 0 return the live pin_in level. Unmapped addresses return 0.
- R11: Writes to the next-value registers (address 2 for bits 7:0, address 3 for bits 15:8) do not change the pins. A new value written between triggers is output on the next selected trigger, which gives a sequence of patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address, also used for reads |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cmp_match | input | 4 | Single-cycle compare-match pulses from timer channels |
| pin_in | input | 16 | Live pin levels |
| pin_out | output | 16 | Pin output values (data registers) |
| pin_oe | output | 16 | Pin output enables (direction registers) |

## Verification
The bench goes after the cases where the enable bit changes the meaning of a data write:
- A design that does not block writes would overwrite a stepped pattern bit.
- A design that lets the write win a same-cycle collision would lose the trigger value.

It retargets a group's select field and then pulses the input that group has left. A design that decodes the fields in the wrong slice, or that ignores the selection, would step the wrong nibble. It also checks transfers into enabled input bits, and it checks the mixed read of data addresses. A design that returns stored data for input bits would miss a change of the live pin level.

// File: rtl/ppp_pkg.sv
package ppp_pkg;

  typedef enum logic [1:0] {
    KIND_DIR  = 2'd0,
    KIND_NEXT = 2'd1,
    KIND_DATA = 2'd2,
    KIND_EN   = 2'd3
  } reg_kind_e;

  localparam int NUM_KINDS = 4;

  function automatic int reg_addr(input reg_kind_e kind, input int port, input int nports);
    return int'(kind) * nports + port;
  endfunction

  function automatic int tsel_addr(input int nports);
    return NUM_KINDS * nports;
  endfunction

endpackage

// File: rtl/ppp_trigger_route.sv
module ppp_trigger_route #(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 4,
  parameter int NUM_TRIG   = 4,
  parameter int SEL_W      = 2
) (
  input  logic [NUM_TRIG-1:0]           cmp_match,
  input  logic [NUM_GROUPS*SEL_W-1:0]   tsel,
  output logic [NUM_GROUPS*GROUP_W-1:0] bit_fire
);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    logic [SEL_W-1:0] sel;
    logic             hit;

    assign sel = tsel[g*SEL_W +: SEL_W];

    always_comb begin
      hit = 1'b0;
      for (int t = 0; t < NUM_TRIG; t++) begin
        if (sel == SEL_W'(t)) hit = cmp_match[t];
      end
    end

    assign bit_fire[g*GROUP_W +: GROUP_W] = {GROUP_W{hit}};
  end

endmodule

// File: rtl/ppp_port_regs.sv
module ppp_port_regs #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_dir,
  input  logic              we_next,
  input  logic              we_data,
  input  logic              we_en,
  input  logic [PORT_W-1:0] wdata,
  input  logic [PORT_W-1:0] fire,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] next_q,
  output logic [PORT_W-1:0] data_q,
  output logic [PORT_W-1:0] en_q
);

  logic [PORT_W-1:0] data_d;

  // Per-bit priority: trigger transfer over software write over hold.
  always_comb begin
    for (int b = 0; b < PORT_W; b++) begin
      data_d[b] = data_q[b];
      if (we_data && !en_q[b]) data_d[b] = wdata[b];
      if (fire[b] && en_q[b])  data_d[b] = next_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      next_q <= '0;
      data_q <= '0;
      en_q   <= '0;
    end else begin
      if (we_dir)  dir_q  <= wdata;
      if (we_next) next_q <= wdata;
      if (we_en)   en_q   <= wdata;
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/ppp_read_mux.sv
module ppp_read_mux
  import ppp_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 4,
  parameter int TSEL_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_PORTS*PORT_W-1:0] dir_all,
  input  logic [NUM_PORTS*PORT_W-1:0] next_all,
  input  logic [NUM_PORTS*PORT_W-1:0] data_all,
  input  logic [NUM_PORTS*PORT_W-1:0] en_all,
  input  logic [TSEL_W-1:0]           tsel,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0]           rdata
);

  logic [PORT_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr == ADDR_W'(reg_addr(KIND_DIR, p, NUM_PORTS)))
        rd_d = dir_all[p*PORT_W +: PORT_W];
      if (addr == ADDR_W'(reg_addr(KIND_NEXT, p, NUM_PORTS)))
        rd_d = next_all[p*PORT_W +: PORT_W];
      if (addr == ADDR_W'(reg_addr(KIND_EN, p, NUM_PORTS)))
        rd_d = en_all[p*PORT_W +: PORT_W];
      if (addr == ADDR_W'(reg_addr(KIND_DATA, p, NUM_PORTS)))
        rd_d = (data_all[p*PORT_W +: PORT_W] & dir_all[p*PORT_W +: PORT_W]) |
               (pin_in[p*PORT_W +: PORT_W]   & ~dir_all[p*PORT_W +: PORT_W]);
    end
    if (addr == ADDR_W'(tsel_addr(NUM_PORTS))) rd_d[TSEL_W-1:0] = tsel;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end

endmodule

// File: rtl/pulse_pattern_port.sv
module pulse_pattern_port
  import ppp_pkg::*;
#(
  parameter int  PORT_W    = 8,
  parameter int  NUM_PORTS = 2,
  parameter int  GROUP_W   = 4,
  parameter int  NUM_TRIG  = 4,
  localparam int TOTAL_W   = PORT_W * NUM_PORTS,
  localparam int ADDR_W    = $clog2(NUM_KINDS * NUM_PORTS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [PORT_W-1:0]  bus_wdata,
  output logic [PORT_W-1:0]  bus_rdata,
  input  logic [NUM_TRIG-1:0] cmp_match,
  input  logic [TOTAL_W-1:0] pin_in,
  output logic [TOTAL_W-1:0] pin_out,
  output logic [TOTAL_W-1:0] pin_oe
);

  localparam int NUM_GROUPS = TOTAL_W / GROUP_W;
  localparam int SEL_W      = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
  localparam int TSEL_W     = NUM_GROUPS * SEL_W;

  logic [TOTAL_W-1:0] dir_flat, next_flat, data_flat, en_flat, fire_flat;
  logic [TSEL_W-1:0]  tsel_q;

  always_ff @(posedge clk) begin
    if (rst) tsel_q <= '0;
    else if (bus_we && bus_addr == ADDR_W'(tsel_addr(NUM_PORTS)))
      tsel_q <= bus_wdata[TSEL_W-1:0];
  end

  ppp_trigger_route #(
    .NUM_GROUPS(NUM_GROUPS),
    .GROUP_W   (GROUP_W),
    .NUM_TRIG  (NUM_TRIG),
    .SEL_W     (SEL_W)
  ) u_route (
    .cmp_match(cmp_match),
    .tsel     (tsel_q),
    .bit_fire (fire_flat)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic we_dir, we_next, we_data, we_en;
    assign we_dir  = bus_we && bus_addr == ADDR_W'(reg_addr(KIND_DIR,  p, NUM_PORTS));
    assign we_next = bus_we && bus_addr == ADDR_W'(reg_addr(KIND_NEXT, p, NUM_PORTS));
    assign we_data = bus_we && bus_addr == ADDR_W'(reg_addr(KIND_DATA, p, NUM_PORTS));
    assign we_en   = bus_we && bus_addr == ADDR_W'(reg_addr(KIND_EN,   p, NUM_PORTS));

    ppp_port_regs #(.PORT_W(PORT_W)) u_regs (
      .clk    (clk),
      .rst    (rst),
      .we_dir (we_dir),
      .we_next(we_next),
      .we_data(we_data),
      .we_en  (we_en),
      .wdata  (bus_wdata),
      .fire   (fire_flat[p*PORT_W +: PORT_W]),
      .dir_q  (dir_flat[p*PORT_W +: PORT_W]),
      .next_q (next_flat[p*PORT_W +: PORT_W]),
      .data_q (data_flat[p*PORT_W +: PORT_W]),
      .en_q   (en_flat[p*PORT_W +: PORT_W])
    );
  end

  ppp_read_mux #(
    .PORT_W   (PORT_W),
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W),
    .TSEL_W   (TSEL_W)
  ) u_read (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .dir_all (dir_flat),
    .next_all(next_flat),
    .data_all(data_flat),
    .en_all  (en_flat),
    .tsel    (tsel_q),
    .pin_in  (pin_in),
    .rdata   (bus_rdata)
  );

  assign pin_out = data_flat;
  assign pin_oe  = dir_flat;

endmodule

// File: rtl/ppp_checker.sv
module ppp_checker
  import ppp_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 2,
  parameter int GROUP_W   = 4,
  parameter int NUM_TRIG  = 4,
  parameter int TOTAL_W   = 16,
  parameter int ADDR_W    = 4,
  parameter int SEL_W     = 2,
  parameter int TSEL_W    = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [PORT_W-1:0]   bus_wdata,
  input logic [NUM_TRIG-1:0] cmp_match,
  input logic [TOTAL_W-1:0]  pin_out,
  input logic [TOTAL_W-1:0]  pin_oe,
  input logic [TOTAL_W-1:0]  en_flat,
  input logic [TOTAL_W-1:0]  next_flat,
  input logic [TSEL_W-1:0]   tsel_q
);

  localparam logic [ADDR_W-1:0] A_DIR0  = ADDR_W'(reg_addr(KIND_DIR, 0, NUM_PORTS));
  localparam logic [ADDR_W-1:0] A_DATA0 = ADDR_W'(reg_addr(KIND_DATA, 0, NUM_PORTS));
  localparam logic [ADDR_W-1:0] A_DATA1 = ADDR_W'(reg_addr(KIND_DATA, 1, NUM_PORTS));

  logic rst_seen_q = 1'b0;
  always_ff @(posedge clk) rst_seen_q <= rst;

  always @(posedge clk) begin
    if (rst_seen_q) begin
      assert_reset_clear_R1: assert (pin_oe == '0 && pin_out == '0)
        else $error("R1 outputs not cleared by reset");
    end
  end

  assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_DIR0) |=> (pin_oe[PORT_W-1:0] == $past(bus_wdata)));

  assert_write_blocked_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_DATA0 && en_flat[0] && !(|cmp_match)) |=> $stable(pin_out[0]));

  assert_transfer_R5: assert property (@(posedge clk) disable iff (rst)
    (cmp_match[tsel_q[SEL_W-1:0]] && en_flat[0]) |=> (pin_out[0] == $past(next_flat[0])));

  assert_quiet_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!(|cmp_match) && !(bus_we && (bus_addr == A_DATA0 || bus_addr == A_DATA1)))
      |=> $stable(pin_out));

endmodule

bind pulse_pattern_port ppp_checker #(
  .PORT_W   (PORT_W),
  .NUM_PORTS(NUM_PORTS),
  .GROUP_W  (GROUP_W),
  .NUM_TRIG (NUM_TRIG),
  .TOTAL_W  (TOTAL_W),
  .ADDR_W   (ADDR_W),
  .SEL_W    (SEL_W),
  .TSEL_W   (TSEL_W)
) u_ppp_checker (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .cmp_match(cmp_match),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .en_flat  (en_flat),
  .next_flat(next_flat),
  .tsel_q   (tsel_q)
);

// File: tb/pulse_pattern_port_bench.sv
module pulse_pattern_port_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  cmp_match = '0;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pulse_pattern_port u_pulse_pattern_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_match(cmp_match),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct packed {
    logic [3:0]  a;
    logic        we;
    logic [7:0]  d;
    logic [3:0]  c;
    logic [15:0] eo;
    logic [15:0] ev;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 1'b1, 8'hFF, 4'h0, 16'h0000, 16'h00FF, 8'd2},  // R2 direction low port
    '{4'd1, 1'b1, 8'h0F, 4'h0, 16'h0000, 16'h0FFF, 8'd2},  // R2 direction high port
    '{4'd4, 1'b1, 8'h5A, 4'h0, 16'h005A, 16'h0FFF, 8'd3},  // R3 plain write
    '{4'd5, 1'b1, 8'hFF, 4'h0, 16'hFF5A, 16'h0FFF, 8'd3},  // R3 plain write high
    '{4'd2, 1'b1, 8'hC3, 4'h0, 16'hFF5A, 16'h0FFF, 8'd11}, // R11 next write no effect
    '{4'd3, 1'b1, 8'h81, 4'h0, 16'hFF5A, 16'h0FFF, 8'd11},
    '{4'd6, 1'b1, 8'hF0, 4'h0, 16'hFF5A, 16'h0FFF, 8'd5},  // R5 enable keeps data
    '{4'd8, 1'b1, 8'hE4, 4'h0, 16'hFF5A, 16'h0FFF, 8'd7},  // R7 select 0,1,2,3
    '{4'd0, 1'b0, 8'h00, 4'h1, 16'hFF5A, 16'h0FFF, 8'd6},  // R6 unenabled / unselected
    '{4'd0, 1'b0, 8'h00, 4'h2, 16'hFFCA, 16'h0FFF, 8'd5},  // R5 group1 steps
    '{4'd4, 1'b1, 8'h00, 4'h0, 16'hFFC0, 16'h0FFF, 8'd4},  // R4 enabled bits blocked
    '{4'd2, 1'b1, 8'h3C, 4'h0, 16'hFFC0, 16'h0FFF, 8'd11},
    '{4'd7, 1'b1, 8'hFF, 4'h0, 16'hFFC0, 16'h0FFF, 8'd5},
    '{4'd0, 1'b0, 8'h00, 4'hC, 16'h81C0, 16'h0FFF, 8'd8},  // R8 input bits still load
    '{4'd4, 1'b1, 8'hFF, 4'h2, 16'h813F, 16'h0FFF, 8'd9},  // R9 collision
    '{4'd2, 1'b1, 8'hA5, 4'h0, 16'h813F, 16'h0FFF, 8'd11},
    '{4'd0, 1'b0, 8'h00, 4'h2, 16'h81AF, 16'h0FFF, 8'd11}, // R11 second pattern
    '{4'd2, 1'b1, 8'h5A, 4'h0, 16'h81AF, 16'h0FFF, 8'd11},
    '{4'd8, 1'b1, 8'hE0, 4'h0, 16'h81AF, 16'h0FFF, 8'd7},  // R7 group1 to input 0
    '{4'd0, 1'b0, 8'h00, 4'h2, 16'h81AF, 16'h0FFF, 8'd7},
    '{4'd0, 1'b0, 8'h00, 4'h1, 16'h815F, 16'h0FFF, 8'd7},
    '{4'd5, 1'b1, 8'h00, 4'h0, 16'h815F, 16'h0FFF, 8'd4}   // R4 blocked on inputs too
  };

  task automatic check(input int req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input int req, input logic [3:0] a, input logic [7:0] exp);
    bus_addr = a;
    bus_we   = 1'b0;
    @(negedge clk);
    check(req, "readback", {24'h0, bus_rdata}, {24'h0, exp});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired: got %0d cycles expected fewer", cyc);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 after reset
    check(1, "pin_out after reset", {16'h0, pin_out}, 32'h0);
    check(1, "pin_oe after reset", {16'h0, pin_oe}, 32'h0);
    check(1, "rdata after reset", {24'h0, bus_rdata}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus_addr  = VEC[i].a;
      bus_we    = VEC[i].we;
      bus_wdata = VEC[i].d;
      cmp_match = VEC[i].c;
      @(negedge clk);
      bus_we    = 1'b0;
      cmp_match = '0;
      check(int'(VEC[i].req), $sformatf("vector %0d pin_out", i), {16'h0, pin_out}, {16'h0, VEC[i].eo});
      check(int'(VEC[i].req), $sformatf("vector %0d pin_oe", i), {16'h0, pin_oe}, {16'h0, VEC[i].ev});
    end

    // R10 readback, mixed data reads use live pins for input bits
    pin_in = 16'hA600;
    rd(10, 4'd8, 8'hE0);
    rd(10, 4'd5, 8'hA1);
    rd(10, 4'd4, 8'h5F);
    rd(10, 4'd2, 8'h5A);
    rd(10, 4'd3, 8'h81);
    rd(10, 4'd6, 8'hF0);
    rd(10, 4'd7, 8'hFF);
    rd(10, 4'd0, 8'hFF);
    rd(10, 4'd1, 8'h0F);
    rd(10, 4'd9, 8'h00);
    rd(10, 4'd15, 8'h00);
    pin_in = 16'h59AA;
    rd(10, 4'd5, 8'h51);
    rd(10, 4'd4, 8'h5F);

    // R1 reset in mid-run
    rst = 1'b1;
    bus_addr = 4'd8;
    @(negedge clk);
    @(negedge clk);
    check(1, "pin_out in reset", {16'h0, pin_out}, 32'h0);
    check(1, "pin_oe in reset", {16'h0, pin_oe}, 32'h0);
    rst = 1'b0;
    rd(1, 4'd8, 8'h00);
    rd(1, 4'd0, 8'h00);
    rd(1, 4'd7, 8'h00);
    rd(1, 4'd4, 8'hAA);

    summary();
  end

endmodule